// File: doc/BRIEF.md
# Line-Scan Pixel Baseline Calibrator

This block learns a per-pixel baseline for a line-scan sensor before any event search runs. The sensor presents two pixels per clock, one even and one odd, for a fixed number of clocks per line, qualified by a line-valid input. Calibration has two passes. The first pass forms one global average for all even pixels and one for all odd pixels over a short run of complete lines. The second pass builds a running sum for every pixel over a long run of lines. During that pass, any pixel brighter than its global average plus a programmable margin counts as its global average instead of its raw value, so passing bright objects do not shift the learned baseline.

When the second pass has seen its full count of lines, the block divides each sum by shifting it and writes the results into an internal pedestal store. A downstream detector reads the store through a registered read port. While the store is written, the block tracks the largest baseline value. After the last write it gives a one-cycle completion pulse and sets a sticky calibrated flag. A restart input clears the flag and runs both passes again.

Top module: `pixel_pedestal_cal`

## Requirements
- R1: A line counts as complete when PAIRS pixel pairs (default 256) arrive within one line-valid high run. Pairs beyond PAIRS in the same run are ignored. After reset or restart, calibration begins only once line-valid has been seen low, so a run already under way is ignored.
- R2: The first pass sums even and odd pixels separately over 2^S1_LINES_LOG2 complete lines (default 16). Each global mean is that sum shifted right by log2(PAIRS)+S1_LINES_LOG2, and it is shown on mean_even / mean_odd.
- R3: If line-valid falls before PAIRS pairs have arrived during the first pass, that line adds nothing to the first-pass sums.
- R4: The second pass accepts pixels only after the first pass has finished and line-valid has then been seen low.
- R5: In the second pass, a pixel whose value exceeds its global mean plus event_thr (compared without overflow) is replaced by that global mean before it is summed.
- R6: The second pass sums 2^S2_LINES_LOG2 complete lines (default 1024). The pedestal is the sum shifted right by S2_LINES_LOG2. Read address k returns the even pixel of pair k on ped_rd_even and the odd pixel on ped_rd_odd, one clock after the address is applied.
- R7: A second-pass line that ends early leaves all sums unchanged. The pass waits for the next line and keeps the lines it has already counted.
- R8: max_pedestal equals the largest of all even and odd pedestals once cal_done has fired. It reads zero after reset and in the cycle after restart, until the next completion, and it stays steady while calibrated is set.
- R9: cal_done is high for exactly one cycle after the last pedestal write. calibrated rises with it and stays set until restart. Restart clears both by the next cycle and starts the first pass again.
- R10: After reset, cal_done, calibrated, max_pedestal, mean_even and mean_odd are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Discard results and calibrate again |
| line_valid | input | 1 | High while pixel pairs belong to a line |
| pix_even | input | PIX_W | Even pixel of the current pair |
| pix_odd | input | PIX_W | Odd pixel of the current pair |
| event_thr | input | PIX_W | Margin above the global mean at which a pixel is rejected |
| ped_rd_addr | input | log2(PAIRS) | Pair index to read from the pedestal store |
| ped_rd_even | output | PIX_W | Even pedestal at the addressed pair, one cycle later |
| ped_rd_odd | output | PIX_W | Odd pedestal at the addressed pair, one cycle later |
| mean_even | output | PIX_W | First-pass global mean of even pixels |
| mean_odd | output | PIX_W | First-pass global mean of odd pixels |
| max_pedestal | output | PIX_W | Largest pedestal written |
| cal_done | output | 1 | One-cycle completion pulse |
| calibrated | output | 1 | Sticky calibration-complete flag |

## Verification
Most internal faults show up only at completion. A wrong pair count, a line counted or dropped wrongly, or a bad gating decision corrupts particular entries of the pedestal store or a global mean. That becomes visible when the store is read back after cal_done, and it may also change max_pedestal. A state error in the sequencer shows up sooner, as a missing or doubled completion pulse, a flag that drops without a restart, or a maximum that moves after calibration. The bench therefore feeds aborted lines, over-long lines, a run already under way at reset, and bright pixels, then compares every stored pedestal and both means against a model.

// File: rtl/pedcal_pkg.sv
package pedcal_pkg;

    // Calibration sequencer states
    typedef enum logic [2:0] {
        ST_S1_ARM = 3'd0,   // wait for line-valid low before pass one
        ST_S1_RUN = 3'd1,   // global mean accumulation
        ST_S2_ARM = 3'd2,   // wait for line-valid low before / between pass-two lines
        ST_S2_RUN = 3'd3,   // per-pixel accumulation
        ST_DUMP   = 3'd4,   // write means to the pedestal store
        ST_HOLD   = 3'd5    // calibrated, idle
    } cal_state_e;

endpackage

// File: rtl/pedcal_line_track.sv
module pedcal_line_track #(
    parameter int PAIRS = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_valid,
    output logic                     pair_ok,
    output logic [$clog2(PAIRS)-1:0] pair_idx,
    output logic                     line_end,
    output logic                     line_abort
);
    localparam int IDX_W = $clog2(PAIRS);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
        logic             full;   // line already complete in this run
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        pair_ok    = line_valid && !trk_q.full;
        pair_idx   = trk_q.cnt;
        line_end   = pair_ok && (trk_q.cnt == IDX_W'(PAIRS - 1));
        line_abort = !line_valid && !trk_q.full && (trk_q.cnt != '0);
        if (!line_valid) begin
            trk_d.cnt  = '0;
            trk_d.full = 1'b0;
        end else if (pair_ok) begin
            if (line_end) begin
                trk_d.cnt  = '0;
                trk_d.full = 1'b1;
            end else begin
                trk_d.cnt = trk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/pedcal_global_mean.sv
module pedcal_global_mean #(
    parameter int PIX_W         = 12,
    parameter int PAIRS         = 256,
    parameter int S1_LINES_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             pair_ok,
    input  logic             line_end,
    input  logic             line_abort,
    input  logic [PIX_W-1:0] pix_even,
    input  logic [PIX_W-1:0] pix_odd,
    output logic             finish,
    output logic [PIX_W-1:0] mean_even,
    output logic [PIX_W-1:0] mean_odd
);
    localparam int IDX_W  = $clog2(PAIRS);
    localparam int LSUM_W = PIX_W + IDX_W;
    localparam int TOT_W  = LSUM_W + S1_LINES_LOG2;

    typedef struct packed {
        logic [LSUM_W-1:0]        line_e;
        logic [LSUM_W-1:0]        line_o;
        logic [TOT_W-1:0]         tot_e;
        logic [TOT_W-1:0]         tot_o;
        logic [S1_LINES_LOG2-1:0] lines;
        logic [PIX_W-1:0]         mean_e;
        logic [PIX_W-1:0]         mean_o;
    } gm_t;

    gm_t gm_d, gm_q;
    logic [TOT_W-1:0] full_e, full_o;

    always_comb begin
        gm_d   = gm_q;
        finish = line_end && (gm_q.lines == '1);
        full_e = gm_q.tot_e + TOT_W'(gm_q.line_e) + TOT_W'(pix_even);
        full_o = gm_q.tot_o + TOT_W'(gm_q.line_o) + TOT_W'(pix_odd);
        if (clear) begin
            gm_d = '0;
        end else if (line_abort) begin
            gm_d.line_e = '0;
            gm_d.line_o = '0;
        end else if (pair_ok) begin
            if (line_end) begin
                gm_d.tot_e  = full_e;
                gm_d.tot_o  = full_o;
                gm_d.line_e = '0;
                gm_d.line_o = '0;
                gm_d.lines  = gm_q.lines + 1'b1;
                if (finish) begin
                    gm_d.mean_e = full_e[TOT_W-1 -: PIX_W];
                    gm_d.mean_o = full_o[TOT_W-1 -: PIX_W];
                end
            end else begin
                gm_d.line_e = gm_q.line_e + LSUM_W'(pix_even);
                gm_d.line_o = gm_q.line_o + LSUM_W'(pix_odd);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gm_q <= '0;
        end else begin
            gm_q <= gm_d;
        end
    end

    assign mean_even = gm_q.mean_e;
    assign mean_odd  = gm_q.mean_o;

endmodule

// File: rtl/pedcal_accum.sv
module pedcal_accum #(
    parameter int PIX_W         = 12,
    parameter int PAIRS         = 256,
    parameter int S2_LINES_LOG2 = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic                     commit,
    input  logic [$clog2(PAIRS)-1:0] addr,
    input  logic [PIX_W-1:0]         pix_even,
    input  logic [PIX_W-1:0]         pix_odd,
    input  logic [PIX_W-1:0]         mean_even,
    input  logic [PIX_W-1:0]         mean_odd,
    input  logic [PIX_W-1:0]         thr,
    output logic                     full,
    output logic [PIX_W-1:0]         avg_even,
    output logic [PIX_W-1:0]         avg_odd
);
    localparam int SUM_W = PIX_W + S2_LINES_LOG2;

    typedef struct packed {
        logic                     sel;    // bank holding committed sums
        logic [S2_LINES_LOG2-1:0] lines;
    } acc_t;

    acc_t acc_d, acc_q;

    logic [SUM_W-1:0] bank_e [2][PAIRS];
    logic [SUM_W-1:0] bank_o [2][PAIRS];

    logic [PIX_W:0]   lvl_e, lvl_o;
    logic [PIX_W-1:0] use_e, use_o;
    logic [SUM_W-1:0] base_e, base_o, cur_e, cur_o, new_e, new_o;

    always_comb begin
        cur_e  = bank_e[acc_q.sel][addr];
        cur_o  = bank_o[acc_q.sel][addr];
        lvl_e  = {1'b0, mean_even} + {1'b0, thr};
        lvl_o  = {1'b0, mean_odd}  + {1'b0, thr};
        use_e  = ({1'b0, pix_even} > lvl_e) ? mean_even : pix_even;
        use_o  = ({1'b0, pix_odd}  > lvl_o) ? mean_odd  : pix_odd;
        base_e = (acc_q.lines == '0) ? '0 : cur_e;
        base_o = (acc_q.lines == '0) ? '0 : cur_o;
        new_e  = base_e + SUM_W'(use_e);
        new_o  = base_o + SUM_W'(use_o);
    end

    always_comb begin
        acc_d = acc_q;
        full  = commit && (acc_q.lines == '1);
        if (clear) begin
            acc_d = '0;
        end else if (commit) begin
            acc_d.sel   = ~acc_q.sel;
            acc_d.lines = acc_q.lines + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // Scratch bank takes committed sum plus this line's contribution
    always_ff @(posedge clk) begin
        if (wr_en) begin
            bank_e[~acc_q.sel][addr] <= new_e;
            bank_o[~acc_q.sel][addr] <= new_o;
        end
    end

    assign avg_even = cur_e[SUM_W-1 -: PIX_W];
    assign avg_odd  = cur_o[SUM_W-1 -: PIX_W];

endmodule

// File: rtl/pedcal_ped_store.sv
module pedcal_ped_store #(
    parameter int PIX_W = 12,
    parameter int PAIRS = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_max,
    input  logic                     wr_en,
    input  logic [$clog2(PAIRS)-1:0] wr_addr,
    input  logic [PIX_W-1:0]         wr_even,
    input  logic [PIX_W-1:0]         wr_odd,
    input  logic [$clog2(PAIRS)-1:0] rd_addr,
    output logic [PIX_W-1:0]         rd_even,
    output logic [PIX_W-1:0]         rd_odd,
    output logic [PIX_W-1:0]         max_val
);
    typedef struct packed {
        logic [PIX_W-1:0] rd_e;
        logic [PIX_W-1:0] rd_o;
        logic [PIX_W-1:0] mx;
    } st_t;

    st_t st_d, st_q;

    logic [PIX_W-1:0] mem_e [PAIRS];
    logic [PIX_W-1:0] mem_o [PAIRS];
    logic [PIX_W-1:0] pair_max;

    always_comb begin
        st_d      = st_q;
        st_d.rd_e = mem_e[rd_addr];
        st_d.rd_o = mem_o[rd_addr];
        pair_max  = (wr_even > wr_odd) ? wr_even : wr_odd;
        if (clear_max) begin
            st_d.mx = '0;
        end else if (wr_en && (pair_max > st_q.mx)) begin
            st_d.mx = pair_max;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_e[wr_addr] <= wr_even;
            mem_o[wr_addr] <= wr_odd;
        end
    end

    assign rd_even = st_q.rd_e;
    assign rd_odd  = st_q.rd_o;
    assign max_val = st_q.mx;

endmodule

// File: rtl/pixel_pedestal_cal.sv
module pixel_pedestal_cal
    import pedcal_pkg::*;
#(
    parameter int PIX_W         = 12,
    parameter int PAIRS         = 256,
    parameter int S1_LINES_LOG2 = 4,
    parameter int S2_LINES_LOG2 = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic                     line_valid,
    input  logic [PIX_W-1:0]         pix_even,
    input  logic [PIX_W-1:0]         pix_odd,
    input  logic [PIX_W-1:0]         event_thr,
    input  logic [$clog2(PAIRS)-1:0] ped_rd_addr,
    output logic [PIX_W-1:0]         ped_rd_even,
    output logic [PIX_W-1:0]         ped_rd_odd,
    output logic [PIX_W-1:0]         mean_even,
    output logic [PIX_W-1:0]         mean_odd,
    output logic [PIX_W-1:0]         max_pedestal,
    output logic                     cal_done,
    output logic                     calibrated
);
    localparam int IDX_W = $clog2(PAIRS);

    typedef struct packed {
        cal_state_e       st;
        logic [IDX_W-1:0] dump_idx;
        logic             done;
        logic             cal;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             pair_ok, line_end, line_abort;
    logic [IDX_W-1:0] pair_idx;
    logic             s1_en, s2_en, dump_en;
    logic             s1_clear, s2_clear, max_clear;
    logic             s1_finish, s2_full;
    logic [IDX_W-1:0] acc_addr;
    logic [PIX_W-1:0] avg_e, avg_o;

    pedcal_line_track #(.PAIRS(PAIRS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_valid (line_valid),
        .pair_ok    (pair_ok),
        .pair_idx   (pair_idx),
        .line_end   (line_end),
        .line_abort (line_abort)
    );

    assign s1_en    = (seq_q.st == ST_S1_RUN);
    assign s2_en    = (seq_q.st == ST_S2_RUN);
    assign dump_en  = (seq_q.st == ST_DUMP);
    assign acc_addr = dump_en ? seq_q.dump_idx : pair_idx;

    pedcal_global_mean #(
        .PIX_W(PIX_W), .PAIRS(PAIRS), .S1_LINES_LOG2(S1_LINES_LOG2)
    ) u_gmean (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (s1_clear),
        .pair_ok    (pair_ok && s1_en),
        .line_end   (line_end && s1_en),
        .line_abort (line_abort && s1_en),
        .pix_even   (pix_even),
        .pix_odd    (pix_odd),
        .finish     (s1_finish),
        .mean_even  (mean_even),
        .mean_odd   (mean_odd)
    );

    pedcal_accum #(
        .PIX_W(PIX_W), .PAIRS(PAIRS), .S2_LINES_LOG2(S2_LINES_LOG2)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (s2_clear),
        .wr_en     (pair_ok && s2_en),
        .commit    (line_end && s2_en),
        .addr      (acc_addr),
        .pix_even  (pix_even),
        .pix_odd   (pix_odd),
        .mean_even (mean_even),
        .mean_odd  (mean_odd),
        .thr       (event_thr),
        .full      (s2_full),
        .avg_even  (avg_e),
        .avg_odd   (avg_o)
    );

    pedcal_ped_store #(.PIX_W(PIX_W), .PAIRS(PAIRS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_max (max_clear),
        .wr_en     (dump_en),
        .wr_addr   (seq_q.dump_idx),
        .wr_even   (avg_e),
        .wr_odd    (avg_o),
        .rd_addr   (ped_rd_addr),
        .rd_even   (ped_rd_even),
        .rd_odd    (ped_rd_odd),
        .max_val   (max_pedestal)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        s1_clear   = 1'b0;
        s2_clear   = 1'b0;
        max_clear  = 1'b0;
        if (restart) begin
            seq_d.st   = ST_S1_ARM;
            seq_d.cal  = 1'b0;
            max_clear  = 1'b1;
        end else begin
            case (seq_q.st)
                ST_S1_ARM: begin
                    if (!line_valid) begin
                        seq_d.st = ST_S1_RUN;
                        s1_clear = 1'b1;
                    end
                end
                ST_S1_RUN: begin
                    if (s1_finish) begin
                        seq_d.st = ST_S2_ARM;
                        s2_clear = 1'b1;
                    end
                end
                ST_S2_ARM: begin
                    if (!line_valid) begin
                        seq_d.st = ST_S2_RUN;
                    end
                end
                ST_S2_RUN: begin
                    if (line_abort) begin
                        seq_d.st = ST_S2_ARM;
                    end else if (s2_full) begin
                        seq_d.st       = ST_DUMP;
                        seq_d.dump_idx = '0;
                        max_clear      = 1'b1;
                    end
                end
                ST_DUMP: begin
                    if (seq_q.dump_idx == IDX_W'(PAIRS - 1)) begin
                        seq_d.st   = ST_HOLD;
                        seq_d.done = 1'b1;
                        seq_d.cal  = 1'b1;
                    end else begin
                        seq_d.dump_idx = seq_q.dump_idx + 1'b1;
                    end
                end
                default: begin
                    seq_d.st = ST_HOLD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st       <= ST_S1_ARM;
            seq_q.dump_idx <= '0;
            seq_q.done     <= 1'b0;
            seq_q.cal      <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cal_done   = seq_q.done;
    assign calibrated = seq_q.cal;

endmodule

// File: rtl/pixel_pedestal_cal_chk.sv
module pixel_pedestal_cal_chk #(
    parameter int PIX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             cal_done,
    input logic             calibrated,
    input logic [PIX_W-1:0] max_pedestal
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);                                     // R9

    AST_DONE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> calibrated);                                    // R9

    AST_FLAG_RISE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calibrated) |-> cal_done);                             // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (calibrated && !restart) |=> calibrated);                    // R9

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!calibrated && !cal_done && max_pedestal == '0)); // R8

    AST_MAX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (calibrated && !restart) |=> $stable(max_pedestal));         // R8

endmodule

bind pixel_pedestal_cal pixel_pedestal_cal_chk #(.PIX_W(PIX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .cal_done     (cal_done),
    .calibrated   (calibrated),
    .max_pedestal (max_pedestal)
);

// File: tb/pixel_pedestal_cal_bench.sv
`timescale 1ns/1ps
module pixel_pedestal_cal_bench;
    localparam int PW = 12;
    localparam int NP = 8;
    localparam int L1 = 2;
    localparam int L2 = 3;
    localparam int AW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic          line_valid = 1'b0;
    logic [PW-1:0] pix_even = '0;
    logic [PW-1:0] pix_odd = '0;
    logic [PW-1:0] event_thr = '0;
    logic [AW-1:0] ped_rd_addr = '0;
    logic [PW-1:0] ped_rd_even, ped_rd_odd, mean_even, mean_odd, max_pedestal;
    logic          cal_done, calibrated;

    always #2.5 clk = ~clk;

    pixel_pedestal_cal #(
        .PIX_W(PW), .PAIRS(NP), .S1_LINES_LOG2(L1), .S2_LINES_LOG2(L2)
    ) u_pixel_pedestal_cal (
        .clk(clk), .rst_n(rst_n), .restart(restart), .line_valid(line_valid),
        .pix_even(pix_even), .pix_odd(pix_odd), .event_thr(event_thr),
        .ped_rd_addr(ped_rd_addr), .ped_rd_even(ped_rd_even), .ped_rd_odd(ped_rd_odd),
        .mean_even(mean_even), .mean_odd(mean_odd), .max_pedestal(max_pedestal),
        .cal_done(cal_done), .calibrated(calibrated)
    );

    typedef struct { int idx; int pe; int po; } exp_t;
    exp_t sb_q[$];

    int n_checks = 0;
    int n_errs   = 0;
    int mon_runs = 0;
    bit finished = 0;

    // reference model state
    int phase, s1n, s2n, tot_e, tot_o, m_e, m_o, thr_v, exp_max;
    int se[NP];
    int so[NP];

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    task automatic model_reset(input int thr);
        phase = 1; s1n = 0; s2n = 0; tot_e = 0; tot_o = 0; m_e = 0; m_o = 0;
        thr_v = thr;
        for (int k = 0; k < NP; k++) begin se[k] = 0; so[k] = 0; end
    endtask

    // Driver: updates the model, pushes expectations, then drives the line
    task automatic drive_line(input int n, input int seed, input int hot_k,
                              input bit hot_odd, input bit counted);
        int ve[NP+4];
        int vo[NP+4];
        for (int i = 0; i < n; i++) begin
            ve[i] = 200 + (seed * 7 + i * 13) % 50;
            vo[i] = 300 + (seed * 11 + i * 5) % 40;
            if (i == hot_k && !hot_odd) ve[i] = 4000;
            if (i == hot_k &&  hot_odd) vo[i] = 4000;
            if (i >= NP) begin ve[i] = 0; vo[i] = 0; end
        end
        if (counted && n >= NP) begin
            if (phase == 1) begin
                for (int k = 0; k < NP; k++) begin tot_e += ve[k]; tot_o += vo[k]; end
                s1n++;
                if (s1n == (1 << L1)) begin
                    m_e = tot_e >> (AW + L1);
                    m_o = tot_o >> (AW + L1);
                    phase = 2;
                end
            end else if (phase == 2) begin
                for (int k = 0; k < NP; k++) begin
                    se[k] += (ve[k] > m_e + thr_v) ? m_e : ve[k];
                    so[k] += (vo[k] > m_o + thr_v) ? m_o : vo[k];
                end
                s2n++;
                if (s2n == (1 << L2)) begin
                    exp_max = 0;
                    for (int k = 0; k < NP; k++) begin
                        exp_t it;
                        it.idx = k; it.pe = se[k] >> L2; it.po = so[k] >> L2;
                        if (it.pe > exp_max) exp_max = it.pe;
                        if (it.po > exp_max) exp_max = it.po;
                        sb_q.push_back(it);
                    end
                    phase = 3;
                end
            end
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_valid = 1'b1;
            pix_even = PW'(ve[i]);
            pix_odd  = PW'(vo[i]);
        end
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            line_valid = 1'b0;
            pix_even = '0;
            pix_odd  = '0;
        end
    endtask

    // Monitor: on completion, compare flags, means, maximum and every stored pedestal
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cal_done) begin
                check("R9 calibrated with done", int'(calibrated), 1);
                check("R8 max_pedestal", int'(max_pedestal), exp_max);
                check("R2 R3 mean_even", int'(mean_even), m_e);
                check("R2 R3 mean_odd", int'(mean_odd), m_o);
                @(negedge clk);
                check("R9 done single cycle", int'(cal_done), 0);
                check("R9 calibrated sticky", int'(calibrated), 1);
                while (sb_q.size() > 0) begin
                    exp_t it;
                    it = sb_q.pop_front();
                    ped_rd_addr = AW'(it.idx);
                    @(negedge clk);
                    // R1 R4 R5 R6 R7 all feed these sums
                    check($sformatf("R1 R4 R5 R6 R7 pedestal even[%0d]", it.idx),
                          int'(ped_rd_even), it.pe);
                    check($sformatf("R1 R4 R5 R6 R7 pedestal odd[%0d]", it.idx),
                          int'(ped_rd_odd), it.po);
                end
                mon_runs++;
            end
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_up();
    end

    initial begin
        // Run one: a bright line already under way at reset release is ignored (R1)
        model_reset(100);
        event_thr  = PW'(100);
        line_valid = 1'b1;
        pix_even   = PW'(4000);
        pix_odd    = PW'(4000);
        for (int i = 0; i < NP + 3; i++) begin
            @(negedge clk);
            if (i == 3) rst_n = 1'b1;
            if (i == 4) begin
                check("R10 reset cal_done", int'(cal_done), 0);
                check("R10 reset calibrated", int'(calibrated), 0);
                check("R10 reset max_pedestal", int'(max_pedestal), 0);
                check("R10 reset mean_even", int'(mean_even), 0);
                check("R10 reset mean_odd", int'(mean_odd), 0);
            end
        end
        @(negedge clk);
        line_valid = 1'b0;
        pix_even = '0;
        pix_odd  = '0;
        for (int g = 0; g < 2; g++) @(negedge clk);

        // pass one: an aborted bright line must not count (R3)
        drive_line(NP, 1, -1, 0, 1);
        drive_line(3, 2, 1, 0, 1);
        drive_line(NP, 3, -1, 0, 1);
        drive_line(NP, 4, -1, 0, 1);
        drive_line(NP, 5, -1, 0, 1);
        // pass two: bright pixels (R5), an over-long line (R1), an aborted line (R7)
        drive_line(NP, 6, -1, 0, 1);
        drive_line(NP, 7, 3, 0, 1);
        drive_line(NP + 2, 8, -1, 0, 1);
        drive_line(5, 9, 0, 1, 1);
        drive_line(NP, 10, 5, 1, 1);
        for (int s = 11; s < 15; s++) drive_line(NP, s, -1, 0, 1);
        wait (mon_runs == 1);

        // Run two: restart clears state (R9, R8); zero margin rejects everything above mean (R5)
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        check("R9 restart clears calibrated", int'(calibrated), 0);
        check("R8 restart clears max_pedestal", int'(max_pedestal), 0);
        model_reset(0);
        event_thr = '0;
        for (int s = 20; s < 24; s++) drive_line(NP, s, -1, 0, 1);
        for (int s = 24; s < 32; s++) drive_line(NP, s, (s == 26) ? 2 : -1, 1, 1);
        wait (mon_runs == 2);
        for (int g = 0; g < 4; g++) @(negedge clk);
        check("R9 calibrated holds after run two", int'(calibrated), 1);
        finish_up();
    end

endmodule